// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a synchronous host and an external asynchronous static RAM. The memory has a 16-bit data word with separate strobes for the upper and lower byte. The host presents one request at a time: a read or a write with an address, write data and a two-bit lane mask. The block accepts the request on a ready/valid handshake and drives the memory strobes, address and data bus. It holds each phase for a whole number of clock cycles, which it computes from nanosecond timing limits and the clock period given as parameters. Read data returns on a one-cycle response strobe. Lanes that the mask leaves out read back as zero.

Every write pulse is shaped so that write enable always closes it. Chip enable and the lane strobes stay low for at least one further cycle after write enable rises. After each read the block keeps its data driver off for a turnaround window before it will accept a write. The data bus is split into an output word, an output-enable and an input word, which the pad ring joins into a tri-state pin.

Top module: `sram_lane_ctrl`

## Requirements
- R1: Out of reset, every memory strobe is high, the data driver is off, no response is pending, and `req_ready` is high.
- R2: An accepted read holds chip enable and output enable low, with write enable high, for exactly RD_CYC cycles (2 by default), starting in the cycle after the accepting edge. The address stays stable for the whole read.
- R3: `rsp_valid` is high for exactly one cycle, the cycle that follows the last read cycle. `rsp_rdata` carries the upper memory byte in bits 15:8 when mask bit 1 is set and the lower byte in bits 7:0 when mask bit 0 is set. An unselected byte is zero.
- R4: An accepted write holds write enable low for WE_CYC cycles (1 by default), starting in the cycle after the accepting edge. The write data is driven on the bus from that first cycle onward.
- R5: Write enable rises while chip enable and the selected lane strobes are still low. They stay low for HOLD_CYC cycles (1 by default) after the rise, and the data driver stays on through those cycles.
- R6: For a write, the upper lane strobe is low only when mask bit 1 is set, and the lower lane strobe is low only when mask bit 0 is set. Reads select their lanes the same way.
- R7: A write whose mask is 00 is accepted in a single cycle. It asserts no strobe, drives no data and leaves the memory contents unchanged.
- R8: After a read's last cycle, `req_ready` stays low for a write request for TA_CYC further cycles (1 by default). The data driver is never on while output enable is low, nor in the cycle after output enable rises.
- R9: `req_ready` is low in every cycle in which a transfer holds chip enable low. A new read is accepted in the first idle cycle.
- R10: Output enable and write enable are never low at the same time. The data driver is on only during a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken at this edge when valid is also high |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | AW | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane select, bit 1 upper byte, bit 0 lower byte |
| rsp_valid | output | 1 | Read data strobe, one cycle |
| rsp_rdata | output | 16 | Read data, unselected bytes zero |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_ub_n | output | 1 | Upper byte strobe, active low |
| sram_lb_n | output | 1 | Lower byte strobe, active low |
| sram_addr | output | AW | Memory address |
| sram_dq_out | output | 16 | Data driven toward the memory |
| sram_dq_oe | output | 1 | Data driver enable |
| sram_dq_in | input | 16 | Data seen on the memory bus |

## Verification
A read accepted at edge k shows its strobes from edge k through edge k+RD_CYC. Its response appears in the cycle after edge k+RD_CYC. A write shows write enable low from edge k, and write enable rises at edge k+WE_CYC. Chip enable releases HOLD_CYC cycles after that rise. The bench model turns every acceptance into a queue of per-cycle expectations and pops one entry per edge. The outputs are compared half a cycle after each edge, so every strobe, the ready level and the response strobe are checked in the exact cycle they are due. The turnaround window is tracked as a countdown that starts at the read's last edge.

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
  parameter int AW     = 18,
  parameter int CLK_NS = 10,
  parameter int T_RC   = 15,
  parameter int T_AA   = 15,
  parameter int T_WC   = 15,
  parameter int T_PWE  = 10,
  parameter int T_SCE  = 10,
  parameter int T_SD   = 8,
  parameter int T_HZ   = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_wdata,
  input  logic [1:0]    req_mask,
  output logic          rsp_valid,
  output logic [15:0]   rsp_rdata,
  output logic          sram_ce_n,
  output logic          sram_we_n,
  output logic          sram_oe_n,
  output logic          sram_ub_n,
  output logic          sram_lb_n,
  output logic [AW-1:0] sram_addr,
  output logic [15:0]   sram_dq_out,
  output logic          sram_dq_oe,
  input  logic [15:0]   sram_dq_in
);

  function automatic int cyc(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_CYC   = imax(1, imax(cyc(T_RC), cyc(T_AA)));
  localparam int WE_CYC   = imax(1, imax(cyc(T_PWE), imax(cyc(T_SCE), cyc(T_SD))));
  localparam int HOLD_CYC = imax(1, cyc(T_WC) - WE_CYC);
  localparam int TA_CYC   = cyc(T_HZ);
  localparam int CW       = $clog2(RD_CYC + WE_CYC + HOLD_CYC + TA_CYC + 2);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WE, S_HOLD} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [CW-1:0] ta_left;
  logic [1:0]    rmask;

  assign req_ready = (st == S_IDLE) && !(req_write && ta_left != '0);

  wire take   = req_valid && req_ready;
  wire nop_wr = req_write && (req_mask == 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      ta_left     <= '0;
      rmask       <= 2'b00;
      sram_ce_n   <= 1'b1;
      sram_we_n   <= 1'b1;
      sram_oe_n   <= 1'b1;
      sram_ub_n   <= 1'b1;
      sram_lb_n   <= 1'b1;
      sram_addr   <= '0;
      sram_dq_out <= '0;
      sram_dq_oe  <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: begin
          if (ta_left != '0) ta_left <= ta_left - 1'b1;
          if (take && !nop_wr) begin
            sram_addr <= req_addr;
            sram_ce_n <= 1'b0;
            sram_ub_n <= ~req_mask[1];
            sram_lb_n <= ~req_mask[0];
            rmask     <= req_mask;
            if (req_write) begin
              sram_we_n   <= 1'b0;
              sram_dq_oe  <= 1'b1;
              sram_dq_out <= req_wdata;
              cnt         <= CW'(WE_CYC - 1);
              st          <= S_WE;
            end else begin
              sram_oe_n <= 1'b0;
              cnt       <= CW'(RD_CYC - 1);
              st        <= S_RD;
            end
          end
        end
        S_RD: begin
          if (cnt == '0) begin
            sram_ce_n <= 1'b1;
            sram_oe_n <= 1'b1;
            sram_ub_n <= 1'b1;
            sram_lb_n <= 1'b1;
            rsp_valid <= 1'b1;
            rsp_rdata <= {rmask[1] ? sram_dq_in[15:8] : 8'h00,
                          rmask[0] ? sram_dq_in[7:0]  : 8'h00};
            ta_left   <= CW'(TA_CYC);
            st        <= S_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_WE: begin
          if (cnt == '0) begin
            sram_we_n <= 1'b1;
            cnt       <= CW'(HOLD_CYC - 1);
            st        <= S_HOLD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (cnt == '0) begin
            sram_ce_n  <= 1'b1;
            sram_ub_n  <= 1'b1;
            sram_lb_n  <= 1'b1;
            sram_dq_oe <= 1'b0;
            st         <= S_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end

  // R2
  rd_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_oe_n && $past(!sram_oe_n)) |-> $stable(sram_addr));

  // R3
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R4
  we_low_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (sram_dq_oe && !sram_ce_n));

  // R5
  we_rise_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (!sram_ce_n && sram_dq_oe && (!sram_ub_n || !sram_lb_n)));

  // R8
  oe_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> !sram_dq_oe);

  // R8
  turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_oe_n) |=> !sram_dq_oe);

  // R9
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_ce_n |-> !req_ready);

  // R10
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!sram_oe_n && !sram_we_n));

endmodule

// File: tb/test_sram_lane_ctrl.sv
module test_sram_lane_ctrl;
  localparam int PERIOD = 10;
  localparam int AW     = 18;
  localparam int RD_N   = 2;  // 15 ns read at 10 ns
  localparam int WE_N   = 1;  // 10 ns pulse, 8 ns setup
  localparam int HOLD_N = 1;  // 15 ns cycle minus pulse
  localparam int TA_N   = 1;  // 7 ns float

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0] req_mask = '0;
  logic req_ready, rsp_valid, ce_n, we_n, oe_n, ub_n, lb_n, dq_oe;
  logic [15:0] rsp_rdata, dq_out, dq_in;
  logic [AW-1:0] m_addr;

  int errors = 0, checks = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  sram_lane_ctrl #(.AW(AW)) i_sram_lane_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sram_ce_n(ce_n), .sram_we_n(we_n), .sram_oe_n(oe_n), .sram_ub_n(ub_n),
    .sram_lb_n(lb_n), .sram_addr(m_addr), .sram_dq_out(dq_out),
    .sram_dq_oe(dq_oe), .sram_dq_in(dq_in));

  logic [15:0] mem [0:255];
  logic [15:0] exp_mem [0:255];

  assign dq_in = {(!ce_n && !oe_n && !ub_n) ? mem[m_addr[7:0]][15:8] : 8'hA5,
                  (!ce_n && !oe_n && !lb_n) ? mem[m_addr[7:0]][7:0]  : 8'h5A};

  always @(posedge we_n) if (!ce_n && dq_oe) begin
    if (!ub_n) mem[m_addr[7:0]][15:8] = dq_out[15:8];
    if (!lb_n) mem[m_addr[7:0]][7:0]  = dq_out[7:0];
  end

  typedef struct packed {
    logic ce, we, oe, ub, lb, doe, fin;
    logic [AW-1:0] addr;
    logic [15:0] dat;
    logic [1:0] msk;
  } ent_t;

  ent_t q[$];
  int ta = 0;
  logic x_rsp = 0;
  logic [15:0] x_rdata = '0;
  string tag = "R1";

  task automatic chk(input string r, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t actual=%h expected=%h", r, $time, act, exp);
    end
  endtask

  always @(posedge clk) if (rst_n) begin
    int pre;
    bit acc;
    ent_t e;
    pre = q.size();
    acc = req_valid && pre == 0 && !(req_write && ta > 0);
    if (pre == 0 && ta > 0) ta--;
    x_rsp = 0;
    if (pre > 0) begin
      e = q.pop_front();
      if (e.fin) begin
        x_rsp = 1;
        x_rdata = {e.msk[1] ? exp_mem[e.addr[7:0]][15:8] : 8'h00,
                   e.msk[0] ? exp_mem[e.addr[7:0]][7:0]  : 8'h00};
        ta = TA_N;
      end
    end
    if (acc && !(req_write && req_mask == 2'b00)) begin
      e = '0;
      e.ce = 0; e.ub = ~req_mask[1]; e.lb = ~req_mask[0];
      e.addr = req_addr; e.msk = req_mask; e.dat = req_wdata;
      if (req_write) begin
        e.doe = 1; e.oe = 1;
        for (int i = 0; i < WE_N; i++) begin e.we = 0; q.push_back(e); end
        for (int i = 0; i < HOLD_N; i++) begin e.we = 1; q.push_back(e); end
        if (req_mask[1]) exp_mem[req_addr[7:0]][15:8] = req_wdata[15:8];
        if (req_mask[0]) exp_mem[req_addr[7:0]][7:0]  = req_wdata[7:0];
      end else begin
        e.we = 1; e.oe = 0; e.doe = 0;
        for (int i = 0; i < RD_N; i++) begin e.fin = (i == RD_N-1); q.push_back(e); end
      end
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      ent_t e;
      string t;
      if (q.size() > 0) begin
        e = q[0];
        t = e.doe ? "R4/R5/R6" : "R2/R6";
        chk(t, {15'd0, ce_n}, {15'd0, e.ce});
        chk(t, {15'd0, we_n}, {15'd0, e.we});
        chk("R2/R10", {15'd0, oe_n}, {15'd0, e.oe});
        chk("R6", {14'd0, ub_n, lb_n}, {14'd0, e.ub, e.lb});
        chk("R8/R10", {15'd0, dq_oe}, {15'd0, e.doe});
        chk("R2", m_addr[15:0], e.addr[15:0]);
        if (e.doe) chk("R4", dq_out, e.dat);
      end else begin
        // R1 idle levels, also after an R7 no-op write
        chk(tag, {11'd0, ce_n, we_n, oe_n, ub_n, lb_n}, 16'h001F);
        chk(tag, {15'd0, dq_oe}, 16'h0000);
      end
      // R8 / R9 ready level
      chk("R8/R9", {15'd0, req_ready},
          {15'd0, q.size() == 0 && !(req_write && ta > 0)});
      // R3 response strobe and data
      chk("R3", {15'd0, rsp_valid}, {15'd0, x_rsp});
      if (x_rsp) chk("R3", rsp_rdata, x_rdata);
    end
  end

  task automatic req(input bit w, input int a, input logic [15:0] d, input logic [1:0] m);
    bit acc;
    req_valid = 1; req_write = w; req_addr = AW'(a); req_wdata = d; req_mask = m;
    do begin
      @(posedge clk); acc = req_ready;
      @(negedge clk);
    end while (!acc);
    req_valid = 0; req_write = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 16'(i * 16'h0101 + 16'h0F00);
      exp_mem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    // R1 reset levels
    chk("R1", {11'd0, ce_n, we_n, oe_n, ub_n, lb_n}, 16'h001F);
    chk("R1", {14'd0, dq_oe, rsp_valid}, 16'h0000);
    chk("R1", {15'd0, req_ready}, 16'h0001);
    rst_n = 1;
    idle(2);
    req(1, 5, 16'hBEEF, 2'b11);
    req(1, 6, 16'h1234, 2'b11);
    idle(1);
    req(0, 5, 16'h0, 2'b11);          // R3 full word
    req(0, 6, 16'h0, 2'b11);          // R9 back-to-back read
    req(1, 7, 16'hAAAA, 2'b10);       // R6 upper lane
    req(1, 8, 16'h7777, 2'b01);       // R6 lower lane
    idle(2);
    req(0, 7, 16'h0, 2'b11);
    req(0, 8, 16'h0, 2'b11);
    tag = "R7";
    req(1, 9, 16'h5555, 2'b00);       // R7 no-op
    idle(2);
    tag = "R1";
    req(0, 9, 16'h0, 2'b11);          // R7 contents unchanged
    req(0, 5, 16'h0, 2'b01);          // R3 upper byte zero
    req(0, 6, 16'h0, 2'b10);          // R3 lower byte zero
    req(0, 3, 16'h0, 2'b11);
    req(1, 3, 16'hCAFE, 2'b11);       // R8 write right after read
    req(0, 3, 16'h0, 2'b11);
    req(1, 4, 16'h0000, 2'b00);       // R7 after read
    req(0, 4, 16'h0, 2'b11);
    idle(4);
    finish_run();
  end

  initial begin
    #(PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule